// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and returns a 17-bit result whose top bit is the carry out of the most significant position. There is no carry-in. The operand bits are split into eight pairs, and carries are formed only at pair boundaries, in three logic levels.

The first level does three things. It forms a generate and a propagate signal for each of the six middle pairs (bits 2–3 up to bits 12–13). It also forms the carry into bit 2 directly from the lowest pair. The second level derives the carries into bits 4, 6, 8, 10, 12 and 14 in one flat lookahead step from that first carry and the pair signals. The third level forms each sum bit from the operand bits and the carry entering its pair, and it forms the final carry out from the top pair.

The result is captured in a register, so a sum is visible one clock after its operands are presented. A new operand pair may be applied on every clock.

Top module: `cla_adder16`

## Requirements
- R1: After each rising clock edge with reset low, `result` equals the 17-bit unsigned sum of the `opa` and `opb` values present at that edge.
- R2: Reset is synchronous and active high. An edge with `rst` high sets `result` to zero, and it stays zero for as long as `rst` is sampled high.
- R3: `result[16]` is the carry out of bit 15. It is 1 exactly when the unsigned sum is 65536 or more, for example 0xFFFF + 0xFFFF gives 0x1FFFE.
- R4: The carry into bit 2 comes only from operand bits 1:0 and equals `a1&b1 | (a1^b1)&a0&b0`. For example, 0x0003 + 0x0001 gives 0x00004.
- R5: The carry into each even bit position 4 through 14 equals the arithmetic carry out of the lower bits. A run of propagating pairs passes a carry from bit 2 up to bit 16, for example 0xFFFF + 0x0001 gives 0x10000.
- R6: For each middle pair, generate is 1 when that pair alone overflows (`a1&b1 | (a1^b1)&a0&b0`), and propagate is 1 when both bit positions of the pair differ between the operands (`(a1^b1)&(a0^b0)`).
- R7: Each sum bit depends only on the operand bits of its pair and the carry entering that pair. Bit 0 is `a0^b0` with no carry-in, so 0x0001 + 0x0000 gives 0x00001.
- R8: Latency is exactly one clock, and a new operand pair may be applied on every clock. Back-to-back pairs produce their sums on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset that clears the result |
| opa | input | 16 | First unsigned operand |
| opb | input | 16 | Second unsigned operand |
| result | output | 17 | Registered sum; bit 16 is the carry out |

## Verification
The assertions check on every cycle that the first-level carry, each pair generate and propagate, and each group carry match an arithmetic reference for the operands on the port. They also check that the registered result equals the sum of the previous operands, that the carry out agrees with bit 15 of the sum, and that reset clears the result. Only the bench scenarios show the targeted cases: carries crossing every pair boundary, full-length propagation from all-ones operands, alternating bit patterns that never carry, and a reset applied in the middle of a stream of back-to-back operands.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int unsigned OPW   = 16;
    localparam int unsigned PAIRW = 2;
    localparam int unsigned NPAIR = OPW / PAIRW;

    typedef struct packed {
        logic gen;
        logic prop;
    } pair_gp_t;

    // Generate and propagate of one 2-bit pair
    function automatic pair_gp_t pair_gp(input logic [1:0] x, input logic [1:0] y);
        pair_gp_t r;
        r.gen  = (x[1] & y[1]) | ((x[1] ^ y[1]) & x[0] & y[0]);
        r.prop = (x[1] ^ y[1]) & (x[0] ^ y[0]);
        return r;
    endfunction

    // Two sum bits of one pair given the carry entering it
    function automatic logic [1:0] pair_sum(input logic [1:0] x, input logic [1:0] y,
                                            input logic cin);
        logic mid;
        mid = (x[0] & y[0]) | ((x[0] ^ y[0]) & cin);
        return {x[1] ^ y[1] ^ mid, x[0] ^ y[0] ^ cin};
    endfunction

endpackage

// File: rtl/cla_gp_stage.sv
module cla_gp_stage
    import cla_pkg::*;
#(
    parameter int unsigned NGRP = cla_pkg::NPAIR
) (
    input  logic [2*NGRP-1:0]         a,
    input  logic [2*NGRP-1:0]         b,
    output pair_gp_t [NGRP-2:1]       gp,
    output logic                      c2
);

    // Lowest pair: no carry-in, so its generate is the carry into bit 2
    pair_gp_t low_gp;
    assign low_gp = pair_gp(a[1:0], b[1:0]);
    assign c2     = low_gp.gen;

    for (genvar k = 1; k <= NGRP - 2; k++) begin : g_mid
        assign gp[k] = pair_gp(a[2*k+1:2*k], b[2*k+1:2*k]);
    end

endmodule

// File: rtl/cla_carry_stage.sv
module cla_carry_stage
    import cla_pkg::*;
#(
    parameter int unsigned NGRP = cla_pkg::NPAIR
) (
    input  logic                 c2,
    input  pair_gp_t [NGRP-2:1]  gp,
    output logic [NGRP-1:1]      grp_cin
);

    assign grp_cin[1] = c2;

    // Flat lookahead: each group carry from c2 and all pair signals below it
    for (genvar k = 2; k <= NGRP - 1; k++) begin : g_cin
        logic cin_k;
        always_comb begin
            logic acc;
            logic run;
            acc = gp[k-1].gen;
            run = gp[k-1].prop;
            for (int j = k - 2; j >= 1; j--) begin
                acc = acc | (run & gp[j].gen);
                run = run & gp[j].prop;
            end
            cin_k = acc | (run & c2);
        end
        assign grp_cin[k] = cin_k;
    end

endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage
    import cla_pkg::*;
#(
    parameter int unsigned NGRP = cla_pkg::NPAIR
) (
    input  logic [2*NGRP-1:0]  a,
    input  logic [2*NGRP-1:0]  b,
    input  logic [NGRP-1:1]    grp_cin,
    output logic [2*NGRP:0]    sum
);

    localparam int unsigned TOP = 2 * NGRP - 2;

    // Lowest pair: no carry-in
    assign sum[0] = a[0] ^ b[0];
    assign sum[1] = a[1] ^ b[1] ^ (a[0] & b[0]);

    for (genvar k = 1; k <= NGRP - 1; k++) begin : g_pair
        assign sum[2*k+1:2*k] = pair_sum(a[2*k+1:2*k], b[2*k+1:2*k], grp_cin[k]);
    end

    // Carry out of the top pair
    logic top_mid;
    assign top_mid       = (a[TOP] & b[TOP]) | ((a[TOP] ^ b[TOP]) & grp_cin[NGRP-1]);
    assign sum[2*NGRP]   = (a[TOP+1] & b[TOP+1]) | ((a[TOP+1] ^ b[TOP+1]) & top_mid);

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = cla_pkg::OPW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  opb,
    output logic [WIDTH:0]    result
);

    localparam int unsigned NGRP = WIDTH / 2;

    pair_gp_t [NGRP-2:1]  gp_w;
    logic                 c2_w;
    logic [NGRP-1:1]      grp_cin_w;
    logic [WIDTH:0]       sum_w;

    // Level 1: pair generate/propagate and carry into bit 2
    cla_gp_stage #(.NGRP(NGRP)) u_gp (
        .a  (opa),
        .b  (opb),
        .gp (gp_w),
        .c2 (c2_w)
    );

    // Level 2: even group carries
    cla_carry_stage #(.NGRP(NGRP)) u_carry (
        .c2      (c2_w),
        .gp      (gp_w),
        .grp_cin (grp_cin_w)
    );

    // Level 3: sum bits
    cla_sum_stage #(.NGRP(NGRP)) u_sum (
        .a       (opa),
        .b       (opb),
        .grp_cin (grp_cin_w),
        .sum     (sum_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else begin
            result <= sum_w;
        end
    end

    // R1 / R8: registered sum of the previous operands
    a_r1_registered_sum: assert property (@(posedge clk) disable iff (rst)
        !rst |=> result == ({1'b0, $past(opa)} + {1'b0, $past(opb)}));

    // R2: reset clears the result
    a_r2_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> result == '0);

    // R3: when top bits differ, carry out is the inverse of bit 15 of the sum
    a_r3_carry_out: assert property (@(posedge clk) disable iff (rst)
        (!rst && (opa[WIDTH-1] ^ opb[WIDTH-1])) |=> result[WIDTH] == !result[WIDTH-1]);

    // R4: carry into bit 2 against a 2-bit arithmetic reference
    logic [2:0] low_ref;
    assign low_ref = {1'b0, opa[1:0]} + {1'b0, opb[1:0]};
    a_r4_low_carry: assert property (@(posedge clk) disable iff (rst)
        c2_w == low_ref[2]);

    // R5: each group carry against a truncated arithmetic reference
    for (genvar k = 1; k <= NGRP - 1; k++) begin : g_chk_cin
        logic [2*k:0] part_ref;
        assign part_ref = {1'b0, opa[2*k-1:0]} + {1'b0, opb[2*k-1:0]};
        a_r5_group_carry: assert property (@(posedge clk) disable iff (rst)
            grp_cin_w[k] == part_ref[2*k]);
    end

    // R6: pair generate/propagate against pair arithmetic
    for (genvar k = 1; k <= NGRP - 2; k++) begin : g_chk_gp
        logic [2:0] pair_ref;
        assign pair_ref = {1'b0, opa[2*k+1:2*k]} + {1'b0, opb[2*k+1:2*k]};
        a_r6_pair_gen: assert property (@(posedge clk) disable iff (rst)
            gp_w[k].gen == pair_ref[2]);
        a_r6_pair_prop: assert property (@(posedge clk) disable iff (rst)
            gp_w[k].prop == ((opa[2*k+1:2*k] ^ opb[2*k+1:2*k]) == 2'b11));
    end

endmodule

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W:0]   result;

    int    n_checks = 0;
    int    n_fail   = 0;
    logic [W:0] exp_pending = '0;
    string      req_pending = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_adder16 dut_i (
        .clk    (clk),
        .rst    (rst),
        .opa    (opa),
        .opb    (opb),
        .result (result)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // One clock: compare the result of the previous edge, then drive new inputs
    task automatic cycle(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic r, input string req);
        @(negedge clk);
        n_checks++;
        if (result !== exp_pending) begin
            n_fail++;
            $display("FAIL %s: result=%h expected=%h", req_pending, result, exp_pending);
        end
        opa = a;
        opb = b;
        rst = r;
        exp_pending = r ? '0 : ({1'b0, a} + {1'b0, b});
        req_pending = req;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: result=%h expected=%h", result, exp_pending);
        summary();
        $finish;
    end

    initial begin
        // R2: held in reset with nonzero operands
        cycle(16'hFFFF, 16'hFFFF, 1'b1, "R2");
        cycle(16'h1234, 16'h4321, 1'b1, "R2");
        // R7: bit 0 without carry-in
        cycle(16'h0001, 16'h0000, 1'b0, "R7");
        cycle(16'h0001, 16'h0001, 1'b0, "R7");
        // R4: carry out of the lowest pair
        cycle(16'h0003, 16'h0001, 1'b0, "R4");
        cycle(16'h0002, 16'h0002, 1'b0, "R4");
        cycle(16'h0002, 16'h0001, 1'b0, "R4");
        // R3: all-ones operands, carry out
        cycle(16'hFFFF, 16'hFFFF, 1'b0, "R3");
        cycle(16'h8000, 16'h8000, 1'b0, "R3");
        // R5: full propagation from bit 0 to bit 16
        cycle(16'hFFFF, 16'h0001, 1'b0, "R5");
        // Alternating patterns: no carries, and all-propagate
        cycle(16'h5555, 16'hAAAA, 1'b0, "R5");
        cycle(16'hAAAA, 16'hAAAA, 1'b0, "R1");
        cycle(16'h5555, 16'h5555, 1'b0, "R1");
        // R5: carry arriving exactly at each pair boundary
        for (int k = 1; k < W/2; k++) begin
            cycle(16'((32'd1 << (2*k)) - 1), 16'h0001, 1'b0, "R5");
        end
        // R6: a middle pair that generates, and one that only propagates
        cycle(16'h000C, 16'h0004, 1'b0, "R6");
        cycle(16'h0C00, 16'h0300, 1'b0, "R6");
        cycle(16'h0CFF, 16'h0301, 1'b0, "R6");
        // R2: reset in the middle of a stream
        cycle(16'h7777, 16'h9999, 1'b1, "R2");
        cycle(16'h0F0F, 16'hF0F1, 1'b0, "R2");
        // R1 / R8: back-to-back random pairs
        for (int i = 0; i < 2000; i++) begin
            cycle(16'($urandom), 16'($urandom), 1'b0, "R8");
        end
        cycle(16'h0000, 16'h0000, 1'b0, "R1");
        summary();
        $finish;
    end

endmodule